// File: doc/BRIEF.md
# Timer Brake and Complementary Output Stage

This block is the last stage of one PWM timer channel. It turns a raw compare reference into a pair of pad signals, a true output and a complementary output. The rising edge of each output is delayed by a programmable dead-time, so the two switches of a half bridge are never on together. A master output-enable chooses between run state, where the reference drives the pads, and idle state, where per-output idle bits drive them. Each pad level is the internal state XORed with that output's polarity bit.

A brake can come from the brake pin or from a clock-failure event. The pin has a selectable active level and an optional digital filter. A brake drops the master enable without waiting for a clock edge and forces both pads to their inactive level at once. If the timer clock keeps running, the clock domain sees the dropped enable after two edges. The pads then move to their idle levels after the dead-time. A sticky brake flag records the event and can raise an interrupt. The master enable comes back either by a software set strobe or automatically on a counter overflow. While the brake is still present, neither the set strobe nor a flag clear has any effect.

Top module: `pwm_safe_out_stage`

## Requirements
- R1: After reset, `moe_o`, `brk_flag_o` and `brk_irq_o` are 0, and the block is in idle state with idle bits taken as 0. Each pad therefore equals its polarity bit, and with `keep_oe_i`=0 both pad enables are 0.
- R2: Each pad level is its internal state XOR its polarity bit (`pol_p_i` for the true output, `pol_n_i` for the complementary one). Internal state 1 means active. An inactive pad therefore equals its polarity bit.
- R3: In run state, the true output's internal state is 1 exactly when `ref_i` is 1 and has been 1 for at least `dt_i` rising clock edges. It falls in the same cycle as `ref_i`. The complementary output behaves the same way on `ref_i`=0. With `dt_i`=0 both follow the reference with no clock delay. Each pad enable equals its per-output enable (`en_p_i`, `en_n_i`). A disabled output stays inactive.
- R4: The two internal states are never both 1 at the same time.
- R5: The brake trigger is `brk_en_i` AND (pin active OR `clk_fail_i`). The pin is active when `brk_pin_i` equals `brk_pol_i`.
- R6: An active brake trigger drives `moe_o` to 0 and forces both pads to their inactive level, with no clock edge needed.
- R7: After a brake with the clock running, each pad whose idle bit is set becomes active after 2 + `dt_i` rising edges, counted from when the brake is asserted.
- R8: In idle state the internal state follows the idle bit (`idle_p_i`, `idle_n_i`), with rising edges delayed by the dead-time. If both idle bits are 1, both outputs stay inactive.
- R9: Once the clock domain sees idle state, `keep_oe_i`=0 makes both pad enables 0. `keep_oe_i`=1 makes both pad enables equal to `en_p_i` OR `en_n_i`.
- R10: `moe_o` goes to 1 at the next clock edge after either a `moe_set_i` strobe or `ovf_i` with `auto_en_i`=1. Neither has any effect while the brake trigger is active.
- R11: With `flt_len_i`=0 the pin is used unfiltered. With `flt_len_i`=N>0, a new pin level is accepted at the N-th consecutive clock edge that samples that level.
- R12: `brk_flag_o` is set at the first clock edge that sees the brake trigger, and then holds. `flag_clr_i` clears it only while the trigger is inactive. `brk_irq_o` is `brk_flag_o` AND `brk_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Raw compare reference |
| dt_i | input | DT_W | Dead-time in clock cycles |
| pol_p_i | input | 1 | Polarity of the true output (1 = active low) |
| pol_n_i | input | 1 | Polarity of the complementary output |
| en_p_i | input | 1 | True output enable |
| en_n_i | input | 1 | Complementary output enable |
| idle_p_i | input | 1 | Idle state of the true output |
| idle_n_i | input | 1 | Idle state of the complementary output |
| keep_oe_i | input | 1 | Keep pad enables driven in idle state |
| moe_set_i | input | 1 | Software strobe that sets the master enable |
| auto_en_i | input | 1 | Re-arm the master enable on overflow |
| ovf_i | input | 1 | Counter overflow strobe |
| brk_pin_i | input | 1 | Brake pin level |
| brk_pol_i | input | 1 | Active level of the brake pin |
| clk_fail_i | input | 1 | Clock-failure event from the clock monitor |
| brk_en_i | input | 1 | Brake enable |
| flt_len_i | input | FLT_W | Brake filter length, 0 = bypass |
| brk_ie_i | input | 1 | Brake interrupt enable |
| flag_clr_i | input | 1 | Brake flag clear strobe |
| pad_p_o | output | 1 | True output pad level |
| pad_n_o | output | 1 | Complementary output pad level |
| pad_oe_p_o | output | 1 | True output pad enable |
| pad_oe_n_o | output | 1 | Complementary output pad enable |
| moe_o | output | 1 | Effective master output-enable |
| brk_flag_o | output | 1 | Sticky brake status flag |
| brk_irq_o | output | 1 | Brake interrupt request |

## Verification
Run state is driven with a random reference whose run lengths are sometimes shorter and sometimes longer than the dead-time. The dead-time and polarity are re-drawn every few dozen cycles. Short runs show whether a pulse shorter than the dead-time is swallowed. Long runs expose any off-by-one in the rising-edge delay. Flipping the polarity separates the internal state from the pad level.

Directed sequences start a brake from the unfiltered pin, from the clock-failure input and from a pin with active-low polarity. The pin-sourced sequences check that pads go safe before any clock edge. The first brake sequence measures the 2 + dead-time settle into idle. A clock-failure event is also applied with the brake disabled, to show that the enable gates both sources. Further sequences hold the brake present while issuing a set strobe, an overflow re-arm and a flag clear, to show that each is blocked. Filter pulses one sample shorter than, and exactly equal to, the programmed length show where glitch rejection ends.

// File: rtl/pso_pkg.sv
package pso_pkg;
    localparam int LEG_P       = 0;
    localparam int LEG_N       = 1;
    localparam int NUM_LEGS    = 2;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/pso_brk_filter.sv
module pso_brk_filter #(
    parameter int FLT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_act_i,
    input  logic [FLT_W-1:0] len_i,
    output logic             filt_o
);
    typedef struct packed {
        logic             lvl;
        logic [FLT_W-1:0] cnt;
    } flt_state_t;

    flt_state_t s_d, s_q;
    logic [FLT_W:0] cnt_inc;
    logic           bypass;

    assign bypass  = (len_i == '0);
    assign cnt_inc = {1'b0, s_q.cnt} + 1'b1;

    always_comb begin
        s_d = s_q;
        if (bypass) begin
            // track the pin so a later switch to filtering starts aligned
            s_d.lvl = pin_act_i;
            s_d.cnt = '0;
        end else if (pin_act_i == s_q.lvl) begin
            s_d.cnt = '0;
        end else if (cnt_inc >= {1'b0, len_i}) begin
            s_d.lvl = pin_act_i;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = cnt_inc[FLT_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign filt_o = bypass ? pin_act_i : s_q.lvl;
endmodule

// File: rtl/pso_dead_time.sv
module pso_dead_time #(
    parameter int DT_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            state_o
);
    localparam logic [DT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [DT_W-1:0] cnt;
    } dt_state_t;

    dt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!req_i)                s_d.cnt = '0;
        else if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // rising edge delayed by dt_i edges, falling edge immediate
    assign state_o = req_i && (s_q.cnt >= dt_i);
endmodule

// File: rtl/pso_master_ctrl.sv
module pso_master_ctrl
    import pso_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic brk_act_i,
    input  logic moe_set_i,
    input  logic auto_en_i,
    input  logic ovf_i,
    input  logic flag_clr_i,
    output logic moe_eff_o,
    output logic moe_sync_o,
    output logic flag_o
);
    typedef struct packed {
        logic                   moe;
        logic [SYNC_STAGES-1:0] sync;
        logic                   flag;
    } mc_state_t;

    mc_state_t s_d, s_q;

    // combinational clear: no clock edge needed for the enable to drop
    assign moe_eff_o = s_q.moe & ~brk_act_i;

    always_comb begin
        s_d = s_q;
        if (brk_act_i)                          s_d.moe = 1'b0;
        else if (moe_set_i || (auto_en_i && ovf_i)) s_d.moe = 1'b1;

        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], moe_eff_o};

        if (brk_act_i)       s_d.flag = 1'b1;
        else if (flag_clr_i) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign moe_sync_o = s_q.sync[SYNC_STAGES-1];
    assign flag_o     = s_q.flag;
endmodule

// File: rtl/pwm_safe_out_stage.sv
module pwm_safe_out_stage
    import pso_pkg::*;
#(
    parameter int DT_W  = 8,
    parameter int FLT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_i,
    input  logic [DT_W-1:0]  dt_i,
    input  logic             pol_p_i,
    input  logic             pol_n_i,
    input  logic             en_p_i,
    input  logic             en_n_i,
    input  logic             idle_p_i,
    input  logic             idle_n_i,
    input  logic             keep_oe_i,
    input  logic             moe_set_i,
    input  logic             auto_en_i,
    input  logic             ovf_i,
    input  logic             brk_pin_i,
    input  logic             brk_pol_i,
    input  logic             clk_fail_i,
    input  logic             brk_en_i,
    input  logic [FLT_W-1:0] flt_len_i,
    input  logic             brk_ie_i,
    input  logic             flag_clr_i,
    output logic             pad_p_o,
    output logic             pad_n_o,
    output logic             pad_oe_p_o,
    output logic             pad_oe_n_o,
    output logic             moe_o,
    output logic             brk_flag_o,
    output logic             brk_irq_o
);
    logic pin_act, pin_filt, brk_act;
    logic moe_eff, moe_sync, override, flag;

    logic [NUM_LEGS-1:0] en_v, pol_v, idle_v;
    logic [NUM_LEGS-1:0] run_req, idle_req, req_v, state_v, pad_v, oe_v;

    assign pin_act = brk_pol_i ? brk_pin_i : ~brk_pin_i;

    pso_brk_filter #(.FLT_W(FLT_W)) u_filter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_act_i (pin_act),
        .len_i     (flt_len_i),
        .filt_o    (pin_filt)
    );

    assign brk_act = brk_en_i & (pin_filt | clk_fail_i);

    pso_master_ctrl u_master (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .brk_act_i  (brk_act),
        .moe_set_i  (moe_set_i),
        .auto_en_i  (auto_en_i),
        .ovf_i      (ovf_i),
        .flag_clr_i (flag_clr_i),
        .moe_eff_o  (moe_eff),
        .moe_sync_o (moe_sync),
        .flag_o     (flag)
    );

    // window where the enable has dropped but the clock domain has not seen it
    assign override = ~moe_eff & moe_sync;

    assign en_v[LEG_P]   = en_p_i;
    assign en_v[LEG_N]   = en_n_i;
    assign pol_v[LEG_P]  = pol_p_i;
    assign pol_v[LEG_N]  = pol_n_i;
    assign idle_v[LEG_P] = idle_p_i;
    assign idle_v[LEG_N] = idle_n_i;

    assign run_req[LEG_P]  = en_p_i & ref_i;
    assign run_req[LEG_N]  = en_n_i & ~ref_i;
    // both idle bits set is refused: neither leg may go active
    assign idle_req[LEG_P] = idle_p_i & ~idle_n_i;
    assign idle_req[LEG_N] = idle_n_i & ~idle_p_i;

    always_comb begin
        if (override)      req_v = '0;
        else if (moe_sync) req_v = run_req;
        else               req_v = idle_req;
    end

    always_comb begin
        if (moe_sync)       oe_v = en_v;
        else if (keep_oe_i) oe_v = {NUM_LEGS{|en_v}};
        else                oe_v = '0;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        pso_dead_time #(.DT_W(DT_W)) u_dt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .req_i   (req_v[g]),
            .dt_i    (dt_i),
            .state_o (state_v[g])
        );
        assign pad_v[g] = state_v[g] ^ pol_v[g];
    end

    assign pad_p_o    = pad_v[LEG_P];
    assign pad_n_o    = pad_v[LEG_N];
    assign pad_oe_p_o = oe_v[LEG_P];
    assign pad_oe_n_o = oe_v[LEG_N];
    assign moe_o      = moe_eff;
    assign brk_flag_o = flag;
    assign brk_irq_o  = flag & brk_ie_i;
endmodule

// File: rtl/pso_checker.sv
module pso_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic pad_p_o,
    input logic pad_n_o,
    input logic pol_p_i,
    input logic pol_n_i,
    input logic pad_oe_p_o,
    input logic pad_oe_n_o,
    input logic keep_oe_i,
    input logic moe_o,
    input logic brk_en_i,
    input logic clk_fail_i,
    input logic brk_flag_o
);
    // R4
    no_dual_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((pad_p_o ^ pol_p_i) && (pad_n_o ^ pol_n_i)));

    // R6
    fail_drops_moe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (brk_en_i && clk_fail_i) |-> !moe_o);

    // R10
    set_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (brk_en_i && clk_fail_i) |=> !moe_o);

    // R12
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (brk_en_i && clk_fail_i) |=> brk_flag_o);

    // R9
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(!moe_o, 1) && $past(!moe_o, 2) && !keep_oe_i) |-> (!pad_oe_p_o && !pad_oe_n_o));
endmodule

bind pwm_safe_out_stage pso_checker u_pso_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pad_p_o    (pad_p_o),
    .pad_n_o    (pad_n_o),
    .pol_p_i    (pol_p_i),
    .pol_n_i    (pol_n_i),
    .pad_oe_p_o (pad_oe_p_o),
    .pad_oe_n_o (pad_oe_n_o),
    .keep_oe_i  (keep_oe_i),
    .moe_o      (moe_o),
    .brk_en_i   (brk_en_i),
    .clk_fail_i (clk_fail_i),
    .brk_flag_o (brk_flag_o)
);

// File: tb/test_pwm_safe_out_stage.sv
`timescale 1ns/1ps
module test_pwm_safe_out_stage;
    localparam int DT_W = 8, FLT_W = 4;

    logic clk = 0, rst_ni = 0;
    logic ref_i = 0;
    logic [DT_W-1:0] dt_i = '0;
    logic pol_p_i = 0, pol_n_i = 0, en_p_i = 1, en_n_i = 1;
    logic idle_p_i = 0, idle_n_i = 0, keep_oe_i = 0;
    logic moe_set_i = 0, auto_en_i = 0, ovf_i = 0;
    logic brk_pin_i = 0, brk_pol_i = 1, clk_fail_i = 0, brk_en_i = 0;
    logic [FLT_W-1:0] flt_len_i = '0;
    logic brk_ie_i = 0, flag_clr_i = 0;
    logic pad_p_o, pad_n_o, pad_oe_p_o, pad_oe_n_o, moe_o, brk_flag_o, brk_irq_o;

    int vecs = 0, errs = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwm_safe_out_stage #(.DT_W(DT_W), .FLT_W(FLT_W)) i_pwm_safe_out_stage (
        .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .dt_i(dt_i),
        .pol_p_i(pol_p_i), .pol_n_i(pol_n_i), .en_p_i(en_p_i), .en_n_i(en_n_i),
        .idle_p_i(idle_p_i), .idle_n_i(idle_n_i), .keep_oe_i(keep_oe_i),
        .moe_set_i(moe_set_i), .auto_en_i(auto_en_i), .ovf_i(ovf_i),
        .brk_pin_i(brk_pin_i), .brk_pol_i(brk_pol_i), .clk_fail_i(clk_fail_i),
        .brk_en_i(brk_en_i), .flt_len_i(flt_len_i), .brk_ie_i(brk_ie_i),
        .flag_clr_i(flag_clr_i), .pad_p_o(pad_p_o), .pad_n_o(pad_n_o),
        .pad_oe_p_o(pad_oe_p_o), .pad_oe_n_o(pad_oe_n_o), .moe_o(moe_o),
        .brk_flag_o(brk_flag_o), .brk_irq_o(brk_irq_o));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic exp_state(input logic req, input int held, input int dt);
        return req && (held >= dt);
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int hp, hn;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1 rst_ni = 1;
        #1;
        // R1 reset state
        chk("R1 moe", moe_o, 0);
        chk("R1 flag", brk_flag_o, 0);
        chk("R1 irq", brk_irq_o, 0);
        chk("R1 pads", {pad_p_o, pad_n_o}, 2'b00);
        chk("R1 oe", {pad_oe_p_o, pad_oe_n_o}, 2'b00);
        // R2 inactive pad equals polarity bit
        pol_p_i = 1; pol_n_i = 1; #1;
        chk("R2 idle pads", {pad_p_o, pad_n_o}, 2'b11);
        pol_p_i = 0; pol_n_i = 0;

        // R10 software set
        moe_set_i = 1; step(); moe_set_i = 0;
        chk("R10 set", moe_o, 1);
        repeat (20) step();
        chk("R3 run oe", {pad_oe_p_o, pad_oe_n_o}, 2'b11);

        // R3 R4 random run-mode traffic; ref has been 0 for 20 edges
        hp = 0; hn = 20;
        for (int cyc = 0; cyc < 600; cyc++) begin
            logic ep, en;
            if (cyc % 40 == 0) begin
                dt_i = DT_W'($urandom % 6);
                pol_p_i = 1'($urandom); pol_n_i = 1'($urandom);
            end
            if ($urandom % 3 == 0) ref_i = ~ref_i;
            #1;
            ep = exp_state(ref_i, hp, int'(dt_i));
            en = exp_state(!ref_i, hn, int'(dt_i));
            chk("R3 true pad", pad_p_o, ep ^ pol_p_i);
            chk("R3 comp pad", pad_n_o, en ^ pol_n_i);
            chk("R4 exclusive", (pad_p_o ^ pol_p_i) & (pad_n_o ^ pol_n_i), 0);
            @(posedge clk);
            hp = ref_i ? hp + 1 : 0;
            hn = ref_i ? 0 : hn + 1;
            #1;
        end

        // R3 disabled leg
        pol_p_i = 0; pol_n_i = 0; dt_i = 0; ref_i = 0; en_n_i = 0;
        step();
        chk("R3 disabled level", pad_n_o, 0);
        chk("R3 disabled oe", {pad_oe_p_o, pad_oe_n_o}, 2'b10);
        en_n_i = 1;

        // R6 R7 brake from unfiltered pin
        ref_i = 1; dt_i = 2; idle_p_i = 1; brk_ie_i = 1;
        brk_en_i = 1; brk_pol_i = 1; flt_len_i = 0;
        repeat (3) step();
        chk("R3 active before brake", pad_p_o, 1);
        brk_pin_i = 1; #1;
        chk("R6 moe async", moe_o, 0);
        chk("R6 pads async", {pad_p_o, pad_n_o}, 2'b00);
        step();
        chk("R12 flag set", brk_flag_o, 1);
        chk("R12 irq", brk_irq_o, 1);
        chk("R7 still safe e1", pad_p_o, 0);
        step();
        chk("R7 dead e2", pad_p_o, 0);
        chk("R9 released oe", {pad_oe_p_o, pad_oe_n_o}, 2'b00);
        step();
        chk("R7 dead e3", pad_p_o, 0);
        step();
        chk("R7 idle e4", pad_p_o, 1);
        chk("R8 comp idle", pad_n_o, 0);

        // R10 R12 blocked while brake present
        moe_set_i = 1; step(); moe_set_i = 0;
        chk("R10 set blocked", moe_o, 0);
        auto_en_i = 1; ovf_i = 1; step(); ovf_i = 0; auto_en_i = 0;
        chk("R10 auto blocked", moe_o, 0);
        flag_clr_i = 1; step();
        chk("R12 clr blocked", brk_flag_o, 1);
        brk_pin_i = 0; step(); flag_clr_i = 0;
        chk("R12 cleared", brk_flag_o, 0);
        chk("R12 irq low", brk_irq_o, 0);

        // R9 keep enables driven
        keep_oe_i = 1; en_p_i = 1; en_n_i = 0; #1;
        chk("R9 keep oe", {pad_oe_p_o, pad_oe_n_o}, 2'b11);
        en_p_i = 0; #1;
        chk("R9 keep none", {pad_oe_p_o, pad_oe_n_o}, 2'b00);
        en_p_i = 1; en_n_i = 1; keep_oe_i = 0;

        // R8 both idle bits refused
        idle_p_i = 1; idle_n_i = 1; dt_i = 0;
        repeat (3) step();
        chk("R8 both idle", {pad_p_o, pad_n_o}, 2'b00);
        pol_p_i = 1; pol_n_i = 1; #1;
        chk("R8 both idle inv", {pad_p_o, pad_n_o}, 2'b11);
        pol_p_i = 0; pol_n_i = 0; idle_p_i = 0; idle_n_i = 0;

        // R10 auto re-enable on overflow
        auto_en_i = 1; ovf_i = 1; step(); ovf_i = 0;
        chk("R10 auto set", moe_o, 1);
        repeat (3) step();

        // R5 brake enable gates clock failure
        brk_en_i = 0; clk_fail_i = 1;
        repeat (2) step();
        chk("R5 gated moe", moe_o, 1);
        chk("R5 gated flag", brk_flag_o, 0);
        brk_en_i = 1; #1;
        chk("R5 clock fail moe", moe_o, 0);
        step();
        chk("R5 clock fail flag", brk_flag_o, 1);
        clk_fail_i = 0; flag_clr_i = 1; step(); flag_clr_i = 0;
        chk("R12 clear after fail", brk_flag_o, 0);
        chk("R10 stays off", moe_o, 0);
        moe_set_i = 1; step(); moe_set_i = 0;
        repeat (3) step();

        // R5 active-low pin
        brk_pol_i = 0; brk_pin_i = 1;
        step();
        chk("R5 low pol idle", moe_o, 1);
        brk_pin_i = 0; #1;
        chk("R5 low pol brake", moe_o, 0);
        brk_pin_i = 1; flag_clr_i = 1; step(); flag_clr_i = 0;
        moe_set_i = 1; step(); moe_set_i = 0;
        chk("R5 re-set", moe_o, 1);

        // R11 filter of length 3
        brk_pol_i = 1; brk_pin_i = 0; flt_len_i = 3;
        repeat (2) step();
        brk_pin_i = 1;
        repeat (2) step();
        chk("R11 short glitch", moe_o, 1);
        brk_pin_i = 0;
        repeat (3) step();
        chk("R11 rejected moe", moe_o, 1);
        chk("R11 rejected flag", brk_flag_o, 0);
        brk_pin_i = 1;
        repeat (2) step();
        chk("R11 not yet", moe_o, 1);
        step();
        chk("R11 accepted", moe_o, 0);
        step();
        chk("R11 flag", brk_flag_o, 1);

        summary();
    end
endmodule